// File: doc/BRIEF.md
# Cascadable presettable synchronous counter

This block is a binary up-counter built from identical 4-bit slices. Each slice has a synchronous clear, a synchronous parallel load and two count enables. One enable is shared by every slice. The other, the carry enable, travels from slice to slice. A slice raises its terminal-count flag when its carry enable is high and its own bits are all ones. That flag becomes the carry enable of the next slice. The chain therefore counts as one wide binary counter, and no extra carry logic sits between the slices.

Each slice decides its operation for the coming edge through a small decoder. The decoder picks one of four operations, handled as states of the slice:
- `OP_CLEAR` when the clear is low.
- Otherwise `OP_LOAD` when the load is low.
- Otherwise `OP_COUNT` when both enables are high.
- Otherwise `OP_HOLD`.

On the next rising edge each operation moves the slice as follows:
- `OP_CLEAR` goes to zero.
- `OP_LOAD` takes the data nibble.
- `OP_COUNT` increments and wraps.
- `OP_HOLD` keeps the value.

The edge that applies an operation is the only transition there is.

An optional modulus mode, selected by an input, shortens the cycle. When the chained count decodes to `MODULUS-1`, the block pulls the shared clear low inside, so the next edge returns the count to zero. The counter then cycles through `MODULUS` states.

Top module: `casc_counter`

## Requirements
- R1: The count changes only at a rising clock edge. Changing any input between edges leaves the count unchanged until the next edge.
- R2: Clear has the highest priority. When `clr_n` is 0 at a rising edge, the count becomes 0, whatever `load_n`, `data`, `en_p` and `en_t` are.
- R3: When `clr_n` is 1 and `load_n` is 0 at a rising edge, the count takes the value of `data`. Bit i of `data` maps to bit i of `count`, and `en_p` and `en_t` have no effect.
- R4: When `clr_n` and `load_n` are 1 and both `en_p` and `en_t` are 1, the count increases by one at the edge.
- R5: When `clr_n` and `load_n` are 1 and either `en_p` or `en_t` is 0, the count keeps its value.
- R6: `tc` is 1 exactly when `en_t` is 1 and every count bit is 1. It does not depend on `en_p` and is combinational from the count.
- R7: Incrementing from the all-ones value gives zero.
- R8: Slice k+1 counts only when slice k shows terminal count. The whole `count` therefore behaves as one binary counter of `STAGES*SLICE_W` bits, carrying across every nibble boundary.
- R9: When `mod_en` is 1 and the count equals `MODULUS-1`, the next edge sets the count to 0, whatever the load and enable inputs are. Counting from zero then visits exactly `MODULUS` states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| data | input | STAGES*SLICE_W | Value loaded by a load |
| en_p | input | 1 | Count enable shared by all slices |
| en_t | input | 1 | Carry enable into the lowest slice |
| mod_en | input | 1 | 1 selects the modulus-`MODULUS` cycle |
| count | output | STAGES*SLICE_W | Chained count value |
| tc | output | 1 | Terminal count of the highest slice |

## Verification
The bench clears the counter while load and both enables are active at the same time. A design with load ahead of clear would show the loaded value instead of zero. It loads all 256 values while driving the enables in every combination. A design that gated load with an enable, or counted during a load, would land one step off.

It counts through the full range, across the nibble carry and the 255-to-0 wrap, and holds at all ones with only one enable high. A broken carry chain would step the upper nibble at the wrong time. A `tc` that depended on `en_p` would drop while the count is held.

Thousands of mixed cycles and a long modulus run check that the count returns to zero right after `MODULUS-1`. The bench also checks that the count never moves between edges.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Operation a slice applies at the next rising edge, highest priority first.
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } slice_op_e;

endpackage

// File: rtl/ctr_slice.sv
module ctr_slice
    import ctr_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          load_n,
    input  logic          en_par,
    input  logic          en_car,
    input  logic [SW-1:0] d,
    output logic [SW-1:0] q,
    output logic          tc
);

    localparam logic [SW-1:0] ONE = SW'(1);

    slice_op_e op;

    // Operation decode: fixed priority clear > load > count > hold.
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_par && en_car)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

    // State register.
    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= d;
            OP_COUNT: q <= q + ONE;
            OP_HOLD:  q <= q;
            default:  q <= q;
        endcase
    end

    // Output process: terminal count is gated only by the carry enable.
    always_comb begin
        tc = en_car && (&q);
    end

    // Assertion arming: becomes 1 once a clear has defined the state.
    logic chk_arm = 1'b0;
    always_ff @(posedge clk) begin
        chk_arm <= chk_arm | ~clr_n;
    end

    p_clear_r2: assert property (@(posedge clk) disable iff (!chk_arm)
        !clr_n |=> (q == '0));

    p_load_r3: assert property (@(posedge clk) disable iff (!chk_arm)
        (clr_n && !load_n) |=> (q == $past(d)));

    p_count_r4: assert property (@(posedge clk) disable iff (!chk_arm)
        (clr_n && load_n && en_par && en_car) |=> (q == SW'($past(q) + ONE)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!chk_arm)
        (clr_n && load_n && !(en_par && en_car)) |=> (q == $past(q)));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!chk_arm)
        (clr_n && load_n && en_par && tc) |=> (q == '0));

    p_tc_gate_r6: assert property (@(posedge clk) disable iff (!chk_arm)
        tc |-> en_car);

endmodule

// File: rtl/ctr_mod_clear.sv
module ctr_mod_clear #(
    parameter int W       = 8,
    parameter int MODULUS = 200
) (
    input  logic [W-1:0] cnt,
    input  logic         mod_en,
    input  logic         clr_in_n,
    output logic         clr_out_n
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    logic at_last;

    always_comb begin
        at_last   = (cnt == LAST);
        clr_out_n = clr_in_n && !(mod_en && at_last);
    end

endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
    parameter int STAGES  = 2,
    parameter int SLICE_W = 4,
    parameter int MODULUS = 200
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic [STAGES*SLICE_W-1:0]   data,
    input  logic                        en_p,
    input  logic                        en_t,
    input  logic                        mod_en,
    output logic [STAGES*SLICE_W-1:0]   count,
    output logic                        tc
);

    localparam int            TOT_W = STAGES * SLICE_W;
    localparam logic [TOT_W-1:0] LAST  = TOT_W'(MODULUS - 1);

    logic [STAGES:0] carry;
    logic            clr_int_n;

    ctr_mod_clear #(
        .W       (TOT_W),
        .MODULUS (MODULUS)
    ) u_modclr (
        .cnt       (count),
        .mod_en    (mod_en),
        .clr_in_n  (clr_n),
        .clr_out_n (clr_int_n)
    );

    assign carry[0] = en_t;

    // Each slice takes its carry enable from the previous slice's terminal count.
    for (genvar g = 0; g < STAGES; g++) begin : g_slice
        ctr_slice #(
            .SW (SLICE_W)
        ) u_slice (
            .clk    (clk),
            .clr_n  (clr_int_n),
            .load_n (load_n),
            .en_par (en_p),
            .en_car (carry[g]),
            .d      (data[g*SLICE_W +: SLICE_W]),
            .q      (count[g*SLICE_W +: SLICE_W]),
            .tc     (carry[g+1])
        );
    end

    assign tc = carry[STAGES];

    logic chk_arm = 1'b0;
    always_ff @(posedge clk) begin
        chk_arm <= chk_arm | ~clr_n;
    end

    p_chain_r8: assert property (@(posedge clk) disable iff (!chk_arm)
        (clr_int_n && load_n && en_p && en_t)
            |=> (count == TOT_W'($past(count) + TOT_W'(1))));

    p_mod_r9: assert property (@(posedge clk) disable iff (!chk_arm)
        (mod_en && count == LAST) |=> (count == '0));

    p_tc_full_r6: assert property (@(posedge clk) disable iff (!chk_arm)
        tc |-> (&count));

endmodule

// File: tb/casc_counter_tb.sv
module casc_counter_tb;

    localparam int ST   = 2;
    localparam int SW   = 4;
    localparam int W    = ST * SW;
    localparam int MODV = 200;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         clr_n  = 1'b1;
    logic         load_n = 1'b1;
    logic         en_p   = 1'b0;
    logic         en_t   = 1'b0;
    logic         mod_en = 1'b0;
    logic [W-1:0] data   = '0;
    logic [W-1:0] count;
    logic         tc;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] model = '0;
    bit known = 1'b0;
    logic [15:0] lf = 16'hACE1;

    casc_counter #(.STAGES(ST), .SLICE_W(SW), .MODULUS(MODV)) u_dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .data(data),
        .en_p(en_p), .en_t(en_t), .mod_en(mod_en), .count(count), .tc(tc)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit c, input bit l, input logic [W-1:0] d,
                        input bit p, input bit t, input bit m);
        logic [W-1:0] nxt;
        string tag;
        bit exp_tc;
        @(negedge clk);
        clr_n = c; load_n = l; data = d; en_p = p; en_t = t; mod_en = m;
        #1;
        if (known) begin
            chk(count == model, "R1", "count between edges", count, model);
            exp_tc = t && (model == '1);
            chk(tc == exp_tc, "R6", "tc", tc, exp_tc);
        end
        if (!c) begin
            nxt = '0; tag = "R2";
        end else if (m && model == W'(MODV - 1)) begin
            nxt = '0; tag = "R9";
        end else if (!l) begin
            nxt = d; tag = "R3";
        end else if (p && t) begin
            nxt = model + 1'b1;
            if (model == '1)            tag = "R7";
            else if (model[3:0] == 4'hF) tag = "R8";
            else                         tag = "R4";
        end else begin
            nxt = model; tag = "R5";
        end
        @(posedge clk);
        #1;
        chk(count == nxt, tag, "count after edge", count, nxt);
        model = nxt;
        known = 1'b1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R2: reset state via clear with load and enables active
        step(1'b0, 1'b0, 8'h5A, 1'b1, 1'b1, 1'b0);
        chk(count == '0, "R2", "reset state", count, 0);

        // R4/R7/R8: full count run with wrap and nibble carries
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);

        // R3: load every value under every enable combination
        for (int v = 0; v < 256; v++) step(1'b1, 1'b0, v[7:0], v[0], v[1], 1'b0);

        // R2: clear beats load, after a nonzero load
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 8'((i * 13) + 7), i[0], i[1], 1'b0);
        end

        // R5/R6: hold at all ones with one enable low
        step(1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);

        // R8: carry blocked at a nibble boundary, then released
        step(1'b1, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);

        // Mixed pseudo-random cycles
        for (int i = 0; i < 2000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[3:0] != 4'h0, lf[7:5] != 3'h0, lf[15:8],
                 lf[4] | lf[9], lf[11] | lf[12], 1'b0);
        end

        // R9: modulus cycle
        step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 8'(MODV - 1), 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 8'h33, 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 8'(MODV - 1), 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 40; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(1'b1, lf[2:0] != 3'h0, lf[15:8], 1'b1, 1'b1, 1'b1);
        end

        finish_run();
    end

endmodule